// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM with 2^19 byte-wide words. The host offers one read or one write at a time over a valid/ready handshake. The controller turns each accepted request into a sequence of chip-select, output-enable and write-enable levels on the RAM pins. Every step lasts a whole number of clock cycles, and each count is derived at elaboration time from a nanosecond minimum and the clock period.

A write keeps output-enable high throughout. Write-enable falls only once the shared data bus has been quiet long enough after any earlier read. The write ends when write-enable rises while chip-select is still low. A read holds chip-select and output-enable low for the access count, registers the bus on the last edge and returns the byte with a one-cycle valid pulse. The controller never drives the bus while the RAM's output drivers may be on.

Top module: `sram_ctrl`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0, `rsp_valid` is 0, and `sram_addr` and `rsp_rdata` are 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. At that edge `sram_addr` loads `req_addr`. Fields presented while `req_ready` is 0 change no output.
- R3: During a write, `sram_ce_n` is 0 from the edge after acceptance to the end of the cycle, and `sram_oe_n` stays 1 throughout. `sram_we_n` is 0 for exactly PULSE cycles. Address and data do not change while `sram_we_n` is 0.
- R4: For a write, `sram_dq_oe` rises together with the fall of `sram_we_n`. It stays 1 through HOLD cycles after `sram_we_n` rises and falls together with `sram_ce_n`. `sram_dq_out` carries the accepted write byte while enabled.
- R5: `sram_we_n` falls (and the driver turns on) no earlier than TURN edges after `sram_oe_n` last rose, and no earlier than one cycle after acceptance.
- R6: During a read, `sram_ce_n` and `sram_oe_n` are both 0 for exactly ACC cycles from the edge after acceptance, with `sram_we_n` at 1 and the driver off. Both then rise on the same edge.
- R7: The byte returned is the value of `sram_dq_in` at the last edge of the access. `rsp_valid` is 1 for one cycle after that edge. `rsp_rdata` holds the byte until the next read completes.
- R8: `req_ready` falls at the accepting edge and returns to 1 on the edge that releases `sram_ce_n`. The next request can be accepted on the following edge.
- R9: With the base count c(t) = max(1, ceil(t_ns / CLK_NS)), the derived counts are PULSE = max(c(we width), c(data setup), c(address-to-end) - 1), HOLD = max(1, c(write cycle) - 1 - PULSE), ACC = max(c(read cycle), c(address access)+1, c(select access)+1, c(output-enable access)+1) and TURN = c(output turn-off).
- R10: `sram_dq_oe` is never 1 while `sram_oe_n` is 0. The address and strobes reach the RAM only while `sram_ce_n` is 0 for an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Last read byte |
| sram_addr | output | ADDR_W | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | DATA_W | Data to the RAM bus |
| sram_dq_oe | output | 1 | Enable for the data-bus driver |
| sram_dq_in | input | DATA_W | Data sampled from the RAM bus |

## Verification
The bound checker watches, on every cycle, the pin-level safety rules. These are: the driver is off whenever output-enable is low, write-enable is low only inside a selected cycle with output-enable high, and address and data hold still during the pulse. It also checks the pulse width, the bus-quiet interval before the driver turns on, the single-cycle response strobe and the low ready level while selected. Only the bench's scenarios can show the exact cycle counts of each phase and the data that moves. These cover: back-to-back read-then-write with its stretched gap, read data sampled on the right edge of a RAM model that is valid only late in the access, extreme addresses, untouched locations, and requests ignored while busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_GAP,
        ST_W_PULSE,
        ST_W_HOLD,
        ST_R_ACC
    } seq_state_e;

    // Strobe bundle as seen on the RAM pins (levels, not functions).
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } pin_ctl_t;

    localparam pin_ctl_t PIN_CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Whole clock cycles that cover a nanosecond minimum, at least one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return imax(1, c);
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // A phase loaded with N ends on the N-th edge after the load.
    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/sram_ctrl_turn.sv
module sram_ctrl_turn #(
    parameter int TURN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    output logic turn_ok
);
    localparam int AGE_W = $clog2(TURN + 1);

    logic [AGE_W-1:0] age;

    // Edges elapsed since output-enable last rose, saturating at TURN.
    always_ff @(posedge clk) begin
        if (rst) begin
            age <= AGE_W'(TURN);
        end else if (!oe_n) begin
            age <= '0;
        end else if (age < AGE_W'(TURN)) begin
            age <= age + 1'b1;
        end
    end

    // The driver turns on at the next edge, which makes the count TURN.
    assign turn_ok = (age >= AGE_W'(TURN - 1));
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int PULSE = 4,
    parameter int HOLD  = 1,
    parameter int ACC   = 7,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic             turn_ok,
    input  logic             t_last,
    output logic             ready,
    output pin_ctl_t         ctl,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             accept,
    output logic             capture
);
    seq_state_e st, st_d;
    pin_ctl_t   ctl_d;
    logic       ready_d;

    assign accept = (st == ST_IDLE) && ready && req_valid;

    always_comb begin
        st_d    = st;
        ctl_d   = ctl;
        ready_d = ready;
        t_load  = 1'b0;
        t_val   = '0;
        capture = 1'b0;
        case (st)
            ST_IDLE: begin
                if (accept) begin
                    ready_d    = 1'b0;
                    ctl_d.ce_n = 1'b0;
                    if (req_we) begin
                        st_d = ST_W_GAP;
                    end else begin
                        st_d       = ST_R_ACC;
                        ctl_d.oe_n = 1'b0;
                        t_load     = 1'b1;
                        t_val      = CNT_W'(ACC);
                    end
                end
            end
            ST_W_GAP: begin
                if (turn_ok) begin
                    st_d       = ST_W_PULSE;
                    ctl_d.we_n = 1'b0;
                    ctl_d.drv  = 1'b1;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(PULSE);
                end
            end
            ST_W_PULSE: begin
                if (t_last) begin
                    st_d       = ST_W_HOLD;
                    ctl_d.we_n = 1'b1;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(HOLD);
                end
            end
            ST_W_HOLD: begin
                if (t_last) begin
                    st_d    = ST_IDLE;
                    ctl_d   = PIN_CTL_IDLE;
                    ready_d = 1'b1;
                end
            end
            ST_R_ACC: begin
                if (t_last) begin
                    st_d    = ST_IDLE;
                    ctl_d   = PIN_CTL_IDLE;
                    ready_d = 1'b1;
                    capture = 1'b1;
                end
            end
            default: begin
                st_d    = ST_IDLE;
                ctl_d   = PIN_CTL_IDLE;
                ready_d = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            ctl   <= PIN_CTL_IDLE;
            ready <= 1'b1;
        end else begin
            st    <= st_d;
            ctl   <= ctl_d;
            ready <= ready_d;
        end
    end
endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
        end else if (accept) begin
            sram_addr <= req_addr;
            if (req_we) begin
                sram_dq_out <= req_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= sram_dq_in;
            end
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_WC_NS   = 55,
    parameter int T_AW_NS   = 45,
    parameter int T_PWE_NS  = 40,
    parameter int T_SD_NS   = 25,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_ACE_NS  = 55,
    parameter int T_DOE_NS  = 25,
    parameter int T_HZOE_NS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int CYC_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int CYC_AW   = ns_to_cyc(T_AW_NS, CLK_NS);
    localparam int CYC_PWE  = ns_to_cyc(T_PWE_NS, CLK_NS);
    localparam int CYC_SD   = ns_to_cyc(T_SD_NS, CLK_NS);
    localparam int CYC_RC   = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int CYC_AA   = ns_to_cyc(T_AA_NS, CLK_NS);
    localparam int CYC_ACE  = ns_to_cyc(T_ACE_NS, CLK_NS);
    localparam int CYC_DOE  = ns_to_cyc(T_DOE_NS, CLK_NS);
    localparam int TURN_CYC = ns_to_cyc(T_HZOE_NS, CLK_NS);

    // Address is already valid one cycle before the pulse starts.
    localparam int PULSE_CYC = imax(imax(CYC_PWE, CYC_SD), CYC_AW - 1);
    localparam int HOLD_CYC  = imax(1, CYC_WC - 1 - PULSE_CYC);
    // One extra cycle of margin before sampling the bus.
    localparam int ACC_CYC   = imax(imax(CYC_RC, CYC_AA + 1), imax(CYC_ACE + 1, CYC_DOE + 1));
    localparam int CNT_W     = $clog2(imax(imax(PULSE_CYC, HOLD_CYC), ACC_CYC) + 1);

    pin_ctl_t         ctl;
    logic             turn_ok;
    logic             t_last;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             accept;
    logic             capture;

    sram_ctrl_seq #(
        .PULSE (PULSE_CYC),
        .HOLD  (HOLD_CYC),
        .ACC   (ACC_CYC),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_we    (req_we),
        .turn_ok   (turn_ok),
        .t_last    (t_last),
        .ready     (req_ready),
        .ctl       (ctl),
        .t_load    (t_load),
        .t_val     (t_val),
        .accept    (accept),
        .capture   (capture)
    );

    sram_ctrl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    sram_ctrl_turn #(
        .TURN (TURN_CYC)
    ) u_turn (
        .clk     (clk),
        .rst     (rst),
        .oe_n    (ctl.oe_n),
        .turn_ok (turn_ok)
    );

    sram_ctrl_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .capture     (capture),
        .sram_dq_in  (sram_dq_in),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    assign sram_ce_n  = ctl.ce_n;
    assign sram_oe_n  = ctl.oe_n;
    assign sram_we_n  = ctl.we_n;
    assign sram_dq_oe = ctl.drv;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int TURN   = 2,
    parameter int PULSE  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic [ADDR_W-1:0] sram_addr
);
    int quiet;
    int wlow;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet <= TURN;
            wlow  <= 0;
        end else begin
            if (!sram_oe_n) quiet <= 0;
            else if (quiet < TURN) quiet <= quiet + 1;
            if (!sram_we_n) wlow <= wlow + 1;
            else wlow <= 0;
        end
    end

    a_r10_no_contention: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);

    a_r4_driver_inside_select: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> !sram_ce_n);

    a_r3_we_inside_select: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));

    a_r6_oe_only_on_read: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (sram_we_n && !sram_ce_n && !sram_dq_oe));

    a_r3_stable_in_pulse: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_dq_out) && $stable(sram_addr)));

    a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_dq_oe) |-> (quiet >= TURN));

    a_r9_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (wlow == PULSE));

    a_r7_rsp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r8_busy_while_selected: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> !req_ready);

    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TURN   (TURN_CYC),
    .PULSE  (PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .sram_ce_n   (sram_ce_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .sram_dq_oe  (sram_dq_oe),
    .sram_dq_out (sram_dq_out),
    .sram_addr   (sram_addr)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HZOE_NS    = 35;

    function automatic int cyc(input int t);
        int c;
        c = (t + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected counts from R9 with the default nanosecond values.
    localparam int P_C    = mx(mx(cyc(40), cyc(25)), cyc(45) - 1);
    localparam int H_C    = mx(1, cyc(55) - 1 - P_C);
    localparam int A_C    = mx(mx(cyc(55), cyc(55) + 1), mx(cyc(55) + 1, cyc(25) + 1));
    localparam int TURN_C = cyc(HZOE_NS);
    localparam int AA_C   = cyc(55);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in = 8'hEE;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_ctrl #(.T_HZOE_NS(HZOE_NS)) i_sram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // ---------------- RAM model (bus valid only late in the access) ----------
    logic [7:0] ram [int];
    logic [7:0] refmem [int];
    int low_cnt = 0;

    function automatic logic [7:0] fill(input int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
    endfunction
    function automatic logic [7:0] ram_rd(input int a);
        if (ram.exists(a)) return ram[a];
        return fill(a);
    endfunction
    function automatic logic [7:0] ref_rd(input int a);
        if (refmem.exists(a)) return refmem[a];
        return fill(a);
    endfunction

    always @(posedge clk) begin
        if (!sram_ce_n && !sram_we_n && sram_dq_oe) ram[int'(sram_addr)] = sram_dq_out;
        if (!sram_ce_n && !sram_oe_n) low_cnt <= low_cnt + 1;
        else low_cnt <= 0;
    end

    always @(negedge clk) begin
        if (!sram_ce_n && !sram_oe_n && low_cnt >= AA_C) sram_dq_in = ram_rd(int'(sram_addr));
        else sram_dq_in = 8'hEE;
    end

    // ---------------- Reference model: event times per request ---------------
    int n = 0, busy_end = 0, op_a = -1, tp = 0, tr = 0, last_rise = -1000;
    bit op_w = 1'b0;
    int op_addr = 0;
    logic [7:0] op_data = 8'h00, hold_rdata = 8'h00;
    bit seen_edge = 1'b0;

    always @(posedge clk) begin
        seen_edge = 1'b1;
        if (rst) begin
            n = 0; busy_end = 0; op_a = -1; op_w = 1'b0; op_addr = 0;
            hold_rdata = 8'h00; last_rise = -1000;
        end else begin
            bit rdy_before;
            int g;
            rdy_before = (n >= busy_end);
            n = n + 1;
            if (req_valid && rdy_before) begin
                op_a    = n;
                op_w    = req_we;
                op_addr = int'(req_addr);
                if (req_we) begin
                    g        = mx(1, last_rise + TURN_C - n);
                    tp       = n + g;
                    tr       = tp + P_C;
                    busy_end = tr + H_C;
                    op_data  = req_wdata;
                    refmem[op_addr] = req_wdata;
                end else begin
                    busy_end  = n + A_C;
                    op_data   = ref_rd(op_addr);
                    last_rise = busy_end;
                end
            end
            if (!op_w && op_a >= 0 && n == busy_end) hold_rdata = op_data;
        end
    end

    always @(negedge clk) begin
        if (seen_edge && !done) begin
            bit in_op;
            in_op = (op_a >= 0) && (n >= op_a) && (n < busy_end);
            chk("R8 req_ready", int'(req_ready), int'(n >= busy_end));
            chk("R2 sram_addr", int'(sram_addr), op_addr);
            chk("R3 R6 sram_ce_n", int'(sram_ce_n), int'(!in_op));
            chk("R6 sram_oe_n", int'(sram_oe_n), int'(!(in_op && !op_w)));
            chk("R3 R9 sram_we_n", int'(sram_we_n), int'(!(in_op && op_w && n >= tp && n < tr)));
            chk("R4 R5 sram_dq_oe", int'(sram_dq_oe), int'(in_op && op_w && n >= tp));
            if (in_op && op_w && n >= tp) chk("R4 sram_dq_out", int'(sram_dq_out), int'(op_data));
            chk("R7 rsp_valid", int'(rsp_valid), int'(!op_w && op_a >= 0 && n == busy_end));
            chk("R7 rsp_rdata", int'(rsp_rdata), int'(hold_rdata));
            checks++;
            if (sram_dq_oe && !sram_oe_n) begin
                errs++;
                $display("FAIL R10 contention actual=1 expected=0");
            end
        end
    end

    // ---------------- Stimulus ----------------
    task automatic issue(input logic we, input int a, input logic [7:0] d);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = 19'(a);
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rest(input int k);
        req_valid = 1'b0;
        req_addr  = 19'h2AAAA;
        req_wdata = 8'h99;
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values at the ports
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 strobes", int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
        chk("R1 dq_oe", int'(sram_dq_oe), 0);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 rsp_rdata", int'(rsp_rdata), 0);

        issue(1'b1, 32'h12345, 8'hA5);       // plain write
        rest(2);
        issue(1'b0, 32'h12345, 8'h00);       // read back
        issue(1'b1, 32'h00000, 8'h3C);       // write right after read: stretched gap (R5)
        issue(1'b0, 32'h00000, 8'h00);       // read right after write
        issue(1'b1, 32'h7FFFF, 8'hFF);       // top address
        issue(1'b0, 32'h7FFFF, 8'h00);
        issue(1'b0, 32'h0ABCD, 8'h00);       // untouched location
        rest(3);
        for (int i = 0; i < 40; i++) begin
            int a;
            case ($urandom_range(0, 3))
                0: a = 0;
                1: a = 32'h7FFFF;
                2: a = 32'h12345;
                default: a = int'($urandom_range(0, 32'h7FFFF));
            endcase
            issue(1'(($urandom_range(0, 1))), a, 8'($urandom_range(0, 255)));
            if ($urandom_range(0, 2) == 0) rest(int'($urandom_range(1, 6)));
        end
        rest(20);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule